// File: doc/BRIEF.md
# General-Purpose Timer with Edge Capture

This block is a free-running up-counter clocked by the functional clock. Software starts and stops it through a control register. It can count on every cycle or after a power-of-two prescaler. When the count wraps past its all-ones value, the counter either reloads a programmed value or stops. A compare stage flags the cycle in which the count steps onto a programmed match value. A capture stage records the count when a selected edge arrives on an external input, into one or two capture registers.

The block produces three single-cycle event pulses: match, overflow and capture. A neighbouring interrupt block decodes them by bit position. A single output pin can be driven three ways: it can follow a static level, toggle, or pulse on overflow or on overflow-or-match. Register writes arrive as one-cycle write strobes that share a data bus. Bus decoding and clock crossing belong to the surrounding logic.

Top module: `gp_capture_timer`

## Requirements
- R1: Control bit 0 runs the counter when set and holds it when clear. After a control write that clears bit 0, the count changes at most once, at the edge of that write, and then stays constant.
- R2: Control bit 5 selects how often the counter advances. When bit 5 is clear, the counter advances on every cycle. When bit 5 is set, it advances once every 2^(v+1) cycles, where v is control bits 4:2. The prescaler restarts on every control write.
- R3: When the count steps past 0xFFFFFFFF and control bit 1 is set, the counter takes the load value and keeps running. Event bit 1 pulses for one cycle.
- R4: When the count steps past 0xFFFFFFFF and control bit 1 is clear, the counter goes to 0 and control bit 0 clears by itself. Event bit 1 pulses for one cycle.
- R5: A counter write places the data in the counter. A write to the trigger strobe, with any data, copies the load value into the counter. A counter write takes priority over a trigger write.
- R6: When control bit 6 is set and a counting step lands on the match value, event bit 0 pulses for one cycle. When bit 6 is clear, event bit 0 never pulses.
- R7: Control bits 9:8 select which capture input edges count: 01 rising, 10 falling, 11 both, 00 none. Each stored capture pulses event bit 2.
- R8: The capture sequence restarts on every control write. Control bit 13 selects the capture mode. In mode 0, the first selected edge stores the count in capture register 1. In mode 1, the first selected edge stores into register 1 and the second into register 2. Once the sequence is complete, further edges are ignored. The stored value is the count that was visible in the cycle the edge was seen.
- R9: Control bits 11:10 select the output trigger: 00 none, 01 overflow only, 10 overflow or match, 11 none.
- R10: Control bit 7 sets the idle output level. Control bit 12 selects the output style. When bit 12 is set, each trigger inverts the output. When bit 12 is clear, each trigger drives the opposite of the idle level for exactly one cycle.
- R11: When control bit 14 is set, the output equals control bit 7 and triggers have no effect on it.
- R12: After reset, the count, control, capture registers and events are zero, and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| cnt_we_i | input | 1 | Counter write strobe |
| load_we_i | input | 1 | Load register write strobe |
| match_we_i | input | 1 | Match register write strobe |
| trig_we_i | input | 1 | Trigger strobe: reload the counter from the load register |
| wdata_i | input | 32 | Write data shared by all strobes |
| cap_in_i | input | 1 | Capture input, already synchronous to clk_i |
| ctrl_o | output | 15 | Current control register |
| count_o | output | 32 | Current count |
| cap1_o | output | 32 | Capture register 1 |
| cap2_o | output | 32 | Capture register 2 |
| evt_o | output | 3 | Event pulses: bit 0 match, bit 1 overflow, bit 2 capture |
| pwm_o | output | 1 | Timer output pin |

## Verification
- **Prescaler faults:** a wrong prescaler phase shows at count_o as a drift that grows with the number of cycles waited. The bench therefore waits long windows of up to several hundred cycles for each divider setting.
- **Capture-sequence faults:** a wrong capture state only shows at the next selected edge, as a capture register that changes when it should not, or a missing event-bit-2 pulse.
- **Output faults:** a stale toggle state shows at pwm_o only after the second trigger, so the bench checks two consecutive overflows.
- **Overflow faults:** an error in overflow handling shows in the cycle right after the wrap, in count_o, evt_o and control bit 0 together.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CTRL_W  = 15;
  localparam int PTV_W   = 3;
  localparam int B_START = 0;
  localparam int B_AR    = 1;
  localparam int B_PTV   = 2;
  localparam int B_PRE   = 5;
  localparam int B_CE    = 6;
  localparam int B_DEF   = 7;
  localparam int B_EDGE  = 8;
  localparam int B_TRG   = 10;
  localparam int B_PT    = 12;
  localparam int B_CAPM  = 13;
  localparam int B_GPO   = 14;

  localparam int EVT_MATCH = 0;
  localparam int EVT_OVF   = 1;
  localparam int EVT_CAP   = 2;
  localparam int EVT_W     = 3;

  typedef enum logic [1:0] {
    TRG_NONE      = 2'b00,
    TRG_OVF       = 2'b01,
    TRG_OVF_MATCH = 2'b10,
    TRG_RSVD      = 2'b11
  } trg_mode_e;

  typedef enum logic [1:0] {
    CAP_FIRST  = 2'b00,
    CAP_SECOND = 2'b01,
    CAP_DONE   = 2'b10
  } cap_state_e;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PTV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [PTV_W-1:0] ptv_i,
  output logic             tick_o
);
  localparam int DIV_W = 2 ** PTV_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] lim;

  // divide ratio 2^(ptv+1); terminal count is ratio-1
  always_comb begin
    span = ({{DIV_W{1'b0}}, 1'b1} << ((PTV_W+1)'(ptv_i) + (PTV_W+1)'(1)));
    lim  = DIV_W'(span - (DIV_W+1)'(1));
  end

  assign tick_o = !en_i || (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (clear_i || !en_i) div_q <= '0;
    else if (div_q == lim)  div_q <= '0;
    else                    div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             ar_i,
  input  logic             ce_i,
  input  logic             cnt_we_i,
  input  logic             trig_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] step_val;
  logic             step;
  logic             wrap;

  assign step     = run_i && tick_i && !cnt_we_i && !trig_we_i;
  assign wrap     = (cnt_q == {CNT_W{1'b1}});
  assign step_val = wrap ? (ar_i ? load_i : '0) : cnt_q + CNT_W'(1);
  assign ovf_o    = step && wrap;
  assign match_o  = step && ce_i && (step_val == match_i);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (cnt_we_i)  cnt_q <= wdata_i;
    else if (trig_we_i) cnt_q <= load_i;
    else if (step)      cnt_q <= step_val;
  end
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rearm_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             mode_i,
  input  logic             cap_in_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap1_o,
  output logic [CNT_W-1:0] cap2_o,
  output logic             cap_o
);
  logic       prev_q;
  logic       hit;
  cap_state_e st_q;
  logic [1:0] store;
  logic [CNT_W-1:0] cap_q [2];

  assign hit = (edge_sel_i[0] && cap_in_i && !prev_q) ||
               (edge_sel_i[1] && !cap_in_i && prev_q);

  always_comb begin
    store = 2'b00;
    if (hit && !rearm_i) begin
      if (st_q == CAP_FIRST)  store[0] = 1'b1;
      if (st_q == CAP_SECOND) store[1] = 1'b1;
    end
  end

  assign cap_o = |store;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      st_q   <= CAP_FIRST;
    end else begin
      prev_q <= cap_in_i;
      if (rearm_i)       st_q <= CAP_FIRST;
      else if (store[0]) st_q <= mode_i ? CAP_SECOND : CAP_DONE;
      else if (store[1]) st_q <= CAP_DONE;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cap_q[g] <= '0;
      else if (store[g]) cap_q[g] <= cnt_i;
    end
  end

  assign cap1_o = cap_q[0];
  assign cap2_o = cap_q[1];
endmodule

// File: rtl/gpt_outgen.sv
module gpt_outgen
  import gpt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  trg_mode_e mode_i,
  input  logic      toggle_i,
  input  logic      idle_lvl_i,
  input  logic      gpo_i,
  input  logic      ovf_i,
  input  logic      match_i,
  output logic      pin_o
);
  logic hit;
  logic tog_q;
  logic pulse_q;

  always_comb begin
    unique case (mode_i)
      TRG_OVF:       hit = ovf_i;
      TRG_OVF_MATCH: hit = ovf_i || match_i;
      default:       hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (mode_i == TRG_NONE || mode_i == TRG_RSVD) tog_q <= 1'b0;
      else if (hit)                                 tog_q <= !tog_q;
    end
  end

  assign pin_o = gpo_i ? idle_lvl_i : (idle_lvl_i ^ (toggle_i ? tog_q : pulse_q));
endmodule

// File: rtl/gp_capture_timer.sv
module gp_capture_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic                cnt_we_i,
  input  logic                load_we_i,
  input  logic                match_we_i,
  input  logic                trig_we_i,
  input  logic [CNT_W-1:0]    wdata_i,
  input  logic                cap_in_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [CNT_W-1:0]    count_o,
  output logic [CNT_W-1:0]    cap1_o,
  output logic [CNT_W-1:0]    cap2_o,
  output logic [EVT_W-1:0]    evt_o,
  output logic                pwm_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  match_q;
  logic [EVT_W-1:0]  evt_q;
  logic              tick;
  logic              ovf_now;
  logic              match_now;
  logic              cap_now;
  logic              run;

  assign run = ctrl_q[B_START];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      evt_q   <= '0;
    end else begin
      if (ctrl_we_i)                   ctrl_q <= wdata_i[CTRL_W-1:0];
      else if (ovf_now && !ctrl_q[B_AR]) ctrl_q[B_START] <= 1'b0;
      if (load_we_i)  load_q  <= wdata_i;
      if (match_we_i) match_q <= wdata_i;
      evt_q[EVT_MATCH] <= match_now;
      evt_q[EVT_OVF]   <= ovf_now;
      evt_q[EVT_CAP]   <= cap_now;
    end
  end

  gpt_prescaler #(.PTV_W(PTV_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (ctrl_we_i || !run),
    .en_i    (ctrl_q[B_PRE]),
    .ptv_i   (ctrl_q[B_PTV +: PTV_W]),
    .tick_o  (tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick),
    .ar_i      (ctrl_q[B_AR]),
    .ce_i      (ctrl_q[B_CE]),
    .cnt_we_i  (cnt_we_i),
    .trig_we_i (trig_we_i),
    .wdata_i   (wdata_i),
    .load_i    (load_q),
    .match_i   (match_q),
    .cnt_o     (count_o),
    .ovf_o     (ovf_now),
    .match_o   (match_now)
  );

  gpt_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rearm_i    (ctrl_we_i),
    .edge_sel_i (ctrl_q[B_EDGE +: 2]),
    .mode_i     (ctrl_q[B_CAPM]),
    .cap_in_i   (cap_in_i),
    .cnt_i      (count_o),
    .cap1_o     (cap1_o),
    .cap2_o     (cap2_o),
    .cap_o      (cap_now)
  );

  gpt_outgen u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (trg_mode_e'(ctrl_q[B_TRG +: 2])),
    .toggle_i   (ctrl_q[B_PT]),
    .idle_lvl_i (ctrl_q[B_DEF]),
    .gpo_i      (ctrl_q[B_GPO]),
    .ovf_i      (ovf_now),
    .match_i    (match_now),
    .pin_o      (pwm_o)
  );

  assign ctrl_o = ctrl_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              cnt_we_i,
  input logic              trig_we_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [CNT_W-1:0]  cap2_o,
  input logic [EVT_W-1:0]  evt_o
);
  AST_HALT_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[B_START] && !cnt_we_i && !trig_we_i) |=> $stable(count_o)); // R1

  AST_ONESHOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o[EVT_OVF] && !ctrl_o[B_AR] && !$past(ctrl_we_i)) |-> !ctrl_o[B_START]); // R4

  AST_CNT_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (count_o == $past(wdata_i))); // R5

  AST_MATCH_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EVT_MATCH] |-> $past(ctrl_o[B_CE])); // R6

  AST_NO_EDGE_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_o[B_EDGE +: 2]) == 2'b00) |-> !evt_o[EVT_CAP]); // R7

  AST_CAP2_MODE1_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_o[B_CAPM]) |-> $stable(cap2_o)); // R8
endmodule

bind gp_capture_timer gpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_we_i (ctrl_we_i),
  .cnt_we_i  (cnt_we_i),
  .trig_we_i (trig_we_i),
  .wdata_i   (wdata_i),
  .ctrl_o    (ctrl_o),
  .count_o   (count_o),
  .cap2_o    (cap2_o),
  .evt_o     (evt_o)
);

// File: tb/gp_capture_timer_tb.sv
`timescale 1ns/1ps
module gp_capture_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0, cnt_we_i = 1'b0, load_we_i = 1'b0;
  logic        match_we_i = 1'b0, trig_we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        cap_in_i = 1'b0;
  logic [14:0] ctrl_o;
  logic [31:0] count_o, cap1_o, cap2_o;
  logic [2:0]  evt_o;
  logic        pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] snap, c1;

  always #2 clk_i = !clk_i;

  gp_capture_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .cnt_we_i(cnt_we_i),
    .load_we_i(load_we_i), .match_we_i(match_we_i), .trig_we_i(trig_we_i),
    .wdata_i(wdata_i), .cap_in_i(cap_in_i), .ctrl_o(ctrl_o), .count_o(count_o),
    .cap1_o(cap1_o), .cap2_o(cap2_o), .evt_o(evt_o), .pwm_o(pwm_o)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] start;
    logic [31:0] wait_n;
    logic [31:0] exp_cnt;
  } vec_t;

  // R2: divider 2^(v+1) from bits 4:2 when bit 5 set
  localparam vec_t VECS [6] = '{
    '{32'h0001, 32'h1000, 32'd7,   32'h1007},
    '{32'h0021, 32'h0000, 32'd9,   32'd4},
    '{32'h0025, 32'h0000, 32'd17,  32'd4},
    '{32'h0029, 32'h0010, 32'd40,  32'h15},
    '{32'h003D, 32'h0000, 32'd600, 32'd2},
    '{32'h0000, 32'h0077, 32'd5,   32'h77}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk_i);
    wdata_i = d;
    case (sel)
      0: ctrl_we_i = 1'b1;
      1: cnt_we_i = 1'b1;
      2: load_we_i = 1'b1;
      3: match_we_i = 1'b1;
      default: trig_we_i = 1'b1;
    endcase
    @(negedge clk_i);
    ctrl_we_i = 1'b0; cnt_we_i = 1'b0; load_we_i = 1'b0;
    match_we_i = 1'b0; trig_we_i = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // drive capture input at a negedge, return after the next negedge
  task automatic cap_drive(input logic v);
    cap_in_i = v;
    @(negedge clk_i);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    check("R12 count", count_o, 0);
    check("R12 ctrl", {17'd0, ctrl_o}, 0);
    check("R12 cap1", cap1_o, 0);
    check("R12 evt/pwm", {28'd0, evt_o, pwm_o}, 0);

    // R2 vector table
    for (int k = 0; k < 6; k++) begin
      wr(0, 0);
      wr(1, VECS[k].start);
      wr(0, VECS[k].ctrl);
      step(int'(VECS[k].wait_n));
      check($sformatf("R2 vec%0d", k), count_o, VECS[k].exp_cnt);
    end

    // R1 stop holds count
    wr(0, 32'h1);
    step(3);
    wr(0, 32'h0);
    snap = count_o;
    step(5);
    check("R1 halt", count_o, snap);

    // R4 one-shot overflow
    wr(1, 32'hFFFF_FFFE);
    wr(0, 32'h1);
    step(2);
    check("R4 count", count_o, 0);
    check("R4 evt", {31'd0, evt_o[1]}, 1);
    check("R4 start cleared", {31'd0, ctrl_o[0]}, 0);
    step(1);
    check("R4 evt one cycle", {31'd0, evt_o[1]}, 0);
    check("R4 stays", count_o, 0);

    // R3 auto-reload
    wr(2, 32'h100);
    wr(1, 32'hFFFF_FFFF);
    wr(0, 32'h3);
    step(1);
    check("R3 reload", count_o, 32'h100);
    check("R3 evt", {31'd0, evt_o[1]}, 1);
    check("R3 running", {31'd0, ctrl_o[0]}, 1);
    step(1);
    check("R3 continues", count_o, 32'h101);

    // R5 trigger reload and direct write
    wr(0, 0);
    wr(2, 32'h55);
    wr(4, 32'hDEAD);
    check("R5 trigger", count_o, 32'h55);
    wr(1, 32'h1234);
    check("R5 write", count_o, 32'h1234);

    // R6 match with and without compare enable
    wr(3, 32'h10);
    wr(1, 32'h0E);
    wr(0, 32'h41);
    step(1);
    check("R6 no early match", {31'd0, evt_o[0]}, 0);
    step(1);
    check("R6 match", {31'd0, evt_o[0]}, 1);
    step(1);
    check("R6 match one cycle", {31'd0, evt_o[0]}, 0);
    wr(0, 0);
    wr(1, 32'h0E);
    wr(0, 32'h01);
    step(2);
    check("R6 ce off", {31'd0, evt_o[0]}, 0);

    // R7/R8 mode 0 rising edge
    wr(0, 0);
    wr(1, 0);
    wr(0, 32'h101);
    step(3);
    snap = count_o;
    cap_drive(1'b1);
    check("R7 rise cap1", cap1_o, snap);
    check("R7 cap evt", {31'd0, evt_o[2]}, 1);
    cap_drive(1'b0);
    check("R7 fall ignored", {31'd0, evt_o[2]}, 0);
    cap_drive(1'b1);
    check("R8 mode0 done", cap1_o, snap);
    check("R8 mode0 no evt", {31'd0, evt_o[2]}, 0);
    check("R8 cap2 untouched", cap2_o, 0);
    cap_drive(1'b0);

    // R8 mode 1 both edges
    wr(0, 0);
    wr(1, 32'h20);
    wr(0, 32'h2301);
    step(2);
    c1 = count_o;
    cap_drive(1'b1);
    step(2);
    snap = count_o;
    cap_drive(1'b0);
    check("R8 mode1 cap1", cap1_o, c1);
    check("R8 mode1 cap2", cap2_o, snap);
    check("R7 both edges evt", {31'd0, evt_o[2]}, 1);
    cap_drive(1'b1);
    check("R8 third ignored", cap1_o, c1);
    cap_drive(1'b0);

    // R7 falling only, and none
    wr(0, 32'h201);
    cap_drive(1'b1);
    check("R7 rise not selected", {31'd0, evt_o[2]}, 0);
    snap = count_o;
    cap_drive(1'b0);
    check("R7 fall cap1", cap1_o, snap);
    wr(0, 32'h001);
    cap_drive(1'b1);
    check("R7 none", {31'd0, evt_o[2]}, 0);
    cap_drive(1'b0);

    // R10 toggle on overflow (R9 mode 01)
    wr(0, 0);
    wr(2, 32'hFFFF_FFFE);
    wr(1, 32'hFFFF_FFFE);
    wr(0, 32'h1403);
    check("R10 toggle idle", {31'd0, pwm_o}, 0);
    step(2);
    check("R10 toggle first", {31'd0, pwm_o}, 1);
    step(2);
    check("R10 toggle second", {31'd0, pwm_o}, 0);

    // R10 pulse on match, idle high (R9 mode 10)
    wr(0, 0);
    wr(3, 32'h10);
    wr(1, 32'h0E);
    wr(0, 32'h08C1);
    check("R10 pulse idle", {31'd0, pwm_o}, 1);
    step(2);
    check("R9 match pulse", {31'd0, pwm_o}, 0);
    step(1);
    check("R10 pulse one cycle", {31'd0, pwm_o}, 1);

    // R9 mode 00 ignores match
    wr(0, 0);
    wr(1, 32'h0E);
    wr(0, 32'h00C1);
    step(2);
    check("R9 none", {31'd0, pwm_o}, 1);

    // R11 general-purpose output ignores triggers
    wr(0, 0);
    wr(2, 32'hFFFF_FFFE);
    wr(1, 32'hFFFF_FFFE);
    wr(0, 32'h5483);
    step(2);
    check("R11 gpo level", {31'd0, pwm_o}, 1);
    check("R11 ovf seen", {31'd0, evt_o[1]}, 1);
    wr(0, 32'h4000);
    check("R11 gpo low", {31'd0, pwm_o}, 0);

    report();
  end
endmodule